// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block is the transmit engine of a serial adapter. The host hands it a byte through a valid/ready holding stage. The engine moves the byte into a shift register and sends one frame on the serial line. A frame is a start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one or two stop bits. A 3-bit format input picks the frame layout. A 2-bit divide input sets how many pulses of the transmit clock enable make up one bit time.

`in_ready` doubles as the holding-register-empty flag. A byte is accepted on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low until the shifter takes the byte at a bit boundary. While it is low, the host must hold `in_valid` and `in_data` stable. If a byte is waiting when a frame ends, the next frame follows with no idle gap. A break input forces the line low. A synchronous master reset drops all transmit state.

Top module: `serial_tx_engine`

## Requirements
- R1: Format codes with `fmt[2]`=0 send 7 data bits followed by a parity bit. `fmt[0]`=0 selects even parity and `fmt[0]`=1 selects odd parity. `fmt[1]`=0 gives two stop bits and `fmt[1]`=1 gives one.
- R2: Format codes with `fmt[2]`=1 send 8 data bits. 100 gives no parity and two stops. 101 gives no parity and one stop. 110 gives even parity and one stop. 111 gives odd parity and one stop.
- R3: Every frame begins with a start bit of 0. Data follows least significant bit first. Stop bits are 1.
- R4: In the 7-bit formats, bit 7 of `in_data` has no effect on the line or on the parity.
- R5: With odd parity, the number of ones in the data bits plus the parity bit is odd. With even parity, that number is even. Formats without parity send no parity bit.
- R6: One bit time lasts 1 `bit_tick` pulse when `div_sel`=00, 16 pulses when `div_sel`=01, and 64 pulses when `div_sel` is 10 or 11.
- R7: `in_ready` is high when the holding register is empty. It goes low on the cycle after an accepted byte. It returns high on the same edge at which that byte's start bit appears on `txd`.
- R8: `txd` idles high. When a byte is accepted while no frame is running, its start bit begins at the next bit boundary, which is at most one bit time later.
- R9: A byte that is waiting when a frame's last stop bit ends starts its frame at once. Back-to-back frames have no idle gap.
- R10: While `brk` is high, `txd` is 0 and no new frame starts. A waiting byte stays held and is sent after `brk` falls.
- R11: When `mreset` is sampled high, the next cycle shows `txd` high, `in_ready` high and `busy` low. Any frame in progress is aborted and any waiting byte is dropped.
- R12: `busy` is high from the first cycle of a start bit to the last cycle of the final stop bit.
- R13: The line changes value only at bit boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreset | input | 1 | Synchronous master reset |
| bit_tick | input | 1 | Transmit clock enable, one pulse per tick |
| div_sel | input | 2 | Tick divide: 00 = 1, 01 = 16, 10/11 = 64 |
| fmt | input | 3 | Frame format code, sampled when a frame is loaded |
| brk | input | 1 | Force the line low (break) |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Holding register empty; byte accepted when valid and ready are both high |
| in_data | input | 8 | Byte to send |
| txd | output | 1 | Serial line |
| busy | output | 1 | Frame in progress |

## Verification
Two things can land on the same clock edge: the last stop bit of one frame ends, and the shifter loads the waiting byte. The bench provokes this by offering three bytes back to back at a divide of 1. A waiting byte is then always ready when the final stop bit ends.

The bench judges the result in two ways. First, `busy` must stay high for exactly three frame lengths with no break. Second, the scoreboard must match each frame bit for bit, sampled at the centre of each bit time. A second such collision is a master reset that arrives while a frame is running and another byte is waiting. After it, the line must be idle and the holding stage empty on the next cycle, and both must stay that way.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;

  localparam int DATA_BITS  = 8;
  localparam int FRAME_BITS = 12;
  localparam int LEN_W      = 4;

  typedef enum logic [1:0] {
    DIV_BY_1   = 2'b00,
    DIV_BY_MID = 2'b01,
    DIV_BY_HI  = 2'b10,
    DIV_BY_HI2 = 2'b11
  } div_code_e;

  typedef struct packed {
    logic [FRAME_BITS-1:0] bits;
    logic [LEN_W-1:0]      len;
  } frame_t;

  // Build an LSB-first frame vector; positions past the payload stay 1 (stop bits).
  function automatic frame_t build_frame(input logic [2:0] code,
                                         input logic [DATA_BITS-1:0] d);
    frame_t f;
    logic   wide, par_en, odd_sel, two_stop, par_bit;
    logic [DATA_BITS-1:0] dm;
    int     nbits, pidx;
    wide     = code[2];
    par_en   = !code[2] || code[1];
    odd_sel  = code[0];
    two_stop = (code[2:1] == 2'b00) || (code == 3'b100);
    dm       = wide ? d : {1'b0, d[DATA_BITS-2:0]};
    par_bit  = (^dm) ^ odd_sel;
    nbits    = wide ? DATA_BITS : DATA_BITS - 1;
    f.bits    = '1;
    f.bits[0] = 1'b0;
    for (int i = 0; i < DATA_BITS; i++) begin
      if (i < nbits) f.bits[i+1] = dm[i];
    end
    pidx = nbits + 1;
    if (par_en) f.bits[pidx] = par_bit;
    f.len = LEN_W'(1 + nbits + (par_en ? 1 : 0) + (two_stop ? 2 : 1));
    return f;
  endfunction

endpackage

// File: rtl/stx_prescaler.sv
module stx_prescaler #(
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic [1:0] div_sel,
  output logic       bit_stb
);
  import serial_tx_pkg::*;

  localparam int CNT_W = (DIV_HIGH > 1) ? $clog2(DIV_HIGH) : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt;
  logic             wrap;

  always_comb begin
    unique case (div_code_e'(div_sel))
      DIV_BY_1:   last_cnt = '0;
      DIV_BY_MID: last_cnt = CNT_W'(DIV_MID - 1);
      default:    last_cnt = CNT_W'(DIV_HIGH - 1);
    endcase
  end

  // >= keeps the count bounded if the divide is lowered mid-count.
  assign wrap    = (cnt >= last_cnt);
  assign bit_stb = tick && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (tick)   cnt <= wrap ? '0 : cnt + 1'b1;
  end

endmodule

// File: rtl/stx_holding.sv
module stx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              take,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data
);

  assign in_ready = !hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (clr) begin
      hold_full <= 1'b0;
    end else if (in_valid && in_ready) begin
      hold_full <= 1'b1;
      hold_data <= in_data;
    end else if (take) begin
      hold_full <= 1'b0;
    end
  end

endmodule

// File: rtl/stx_shifter.sv
module stx_shifter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       bit_stb,
  input  logic       brk,
  input  logic [2:0] fmt,
  input  logic       hold_full,
  input  logic [serial_tx_pkg::DATA_BITS-1:0] hold_data,
  output logic       take,
  output logic       line_q,
  output logic       busy
);
  import serial_tx_pkg::*;

  logic [FRAME_BITS-1:0] sr;
  logic [LEN_W-1:0]      remain;
  logic                  active;
  logic                  last_bit;
  frame_t                nxt;

  assign last_bit = active && (remain == LEN_W'(1));
  assign take     = bit_stb && hold_full && !brk && (!active || last_bit);
  assign nxt      = build_frame(fmt, hold_data);
  assign busy     = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '1;
      remain <= '0;
      active <= 1'b0;
      line_q <= 1'b1;
    end else if (clr) begin
      sr     <= '1;
      remain <= '0;
      active <= 1'b0;
      line_q <= 1'b1;
    end else if (bit_stb) begin
      if (take) begin
        line_q <= nxt.bits[0];
        sr     <= {1'b1, nxt.bits[FRAME_BITS-1:1]};
        remain <= nxt.len;
        active <= 1'b1;
      end else if (active && !last_bit) begin
        line_q <= sr[0];
        sr     <= {1'b1, sr[FRAME_BITS-1:1]};
        remain <= remain - 1'b1;
      end else if (active) begin
        line_q <= 1'b1;
        remain <= '0;
        active <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/serial_tx_engine.sv
module serial_tx_engine #(
  parameter int DIV_MID  = 16,
  parameter int DIV_HIGH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mreset,
  input  logic       bit_tick,
  input  logic [1:0] div_sel,
  input  logic [2:0] fmt,
  input  logic       brk,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  output logic       txd,
  output logic       busy
);
  import serial_tx_pkg::*;

  logic                 bit_stb;
  logic                 take;
  logic                 hold_full;
  logic [DATA_BITS-1:0] hold_data;
  logic                 line_q;

  stx_prescaler #(.DIV_MID(DIV_MID), .DIV_HIGH(DIV_HIGH)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(mreset), .tick(bit_tick),
    .div_sel(div_sel), .bit_stb(bit_stb)
  );

  stx_holding #(.DATA_W(DATA_BITS)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(mreset), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .take(take),
    .hold_full(hold_full), .hold_data(hold_data)
  );

  stx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .clr(mreset), .bit_stb(bit_stb), .brk(brk),
    .fmt(fmt), .hold_full(hold_full), .hold_data(hold_data),
    .take(take), .line_q(line_q), .busy(busy)
  );

  assign txd = brk ? 1'b0 : line_q;

endmodule

// File: rtl/stx_checker.sv
module stx_checker (
  input logic clk,
  input logic rst_n,
  input logic mreset,
  input logic brk,
  input logic in_valid,
  input logic in_ready,
  input logic txd,
  input logic busy,
  input logic bit_stb,
  input logic line_q
);

  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |-> txd);

  p_break_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);

  p_master_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mreset |=> (in_ready && !busy && (txd || brk)));

  p_accept_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !mreset) |=> !in_ready);

  p_ready_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> ($past(bit_stb) || $past(mreset)));

  p_bit_boundary_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb && !mreset) |=> $stable(line_q));

  p_low_only_in_frame_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(line_q) |-> busy);

endmodule

bind serial_tx_engine stx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mreset(mreset), .brk(brk),
  .in_valid(in_valid), .in_ready(in_ready), .txd(txd), .busy(busy),
  .bit_stb(bit_stb), .line_q(line_q)
);

// File: tb/serial_tx_engine_bench.sv
module serial_tx_engine_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mreset = 1'b0;
  logic       bit_tick = 1'b0;
  logic [1:0] div_sel = 2'b00;
  logic [2:0] fmt = 3'b000;
  logic       brk = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, txd, busy;

  typedef struct {
    logic [11:0] bits;
    int          len;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_checks = 0;
  int   n_fail = 0;
  int   tick_period = 1;
  int   per = 1;

  always #2 clk = ~clk;

  serial_tx_engine u_serial_tx_engine (
    .clk(clk), .rst_n(rst_n), .mreset(mreset), .bit_tick(bit_tick),
    .div_sel(div_sel), .fmt(fmt), .brk(brk), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .txd(txd), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Expected frame from the requirement text.
  function automatic exp_t model(input logic [2:0] c, input logic [7:0] d, input string tag);
    exp_t e;
    int   nd, k;
    bit   has_par, odd, two;
    int   ones;
    nd      = c[2] ? 8 : 7;
    has_par = (c[2] == 1'b0) || (c == 3'b110) || (c == 3'b111);
    odd     = c[0];
    two     = (c == 3'b000) || (c == 3'b001) || (c == 3'b100);
    e.bits  = 12'hFFF;
    e.bits[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < nd; i++) begin
      e.bits[i+1] = d[i];
      if (d[i]) ones++;
    end
    k = nd + 1;
    if (has_par) begin
      e.bits[k] = odd ? ((ones % 2) == 0) : ((ones % 2) == 1);
      k++;
    end
    e.len = k + (two ? 2 : 1);
    e.tag = tag;
    return e;
  endfunction

  // Tick generator
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (cnt >= tick_period - 1) begin
        bit_tick = 1'b1;
        cnt = 0;
      end else begin
        bit_tick = 1'b0;
        cnt++;
      end
    end
  end

  // Driver: offers a byte, pushes the expected frame when accepted.
  task automatic send(input logic [7:0] d, input bit push, input string tag);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    if (push) q.push_back(model(fmt, d, tag));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int guard;
    guard = 0;
    while ((q.size() != 0 || busy || !in_ready) && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
  endtask

  // Monitor: on each start edge pops one frame and samples every bit at its centre.
  initial begin
    logic prev;
    exp_t e;
    logic [11:0] got;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n && q.size() != 0 && prev && !txd) begin
        e = q.pop_front();
        got = 12'hFFF;
        repeat ((per - 1) / 2) @(negedge clk);
        for (int k = 0; k < e.len; k++) begin
          got[k] = txd;
          if (k < e.len - 1) repeat (per) @(negedge clk);
        end
        check(got == e.bits, e.tag, int'(got), int'(e.bits));
      end
      prev = txd;
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    summary();
  end

  initial begin
    int cnt;
    bit seen;
    repeat (3) @(negedge clk);
    check(txd == 1'b1, "R8 reset idle", txd, 1);
    check(in_ready == 1'b1, "R7 reset ready", in_ready, 1);
    check(busy == 1'b0, "R12 reset busy", busy, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // All eight formats at divide 1
    div_sel = 2'b00; tick_period = 1; per = 1;
    for (int c = 0; c < 8; c++) begin
      fmt = 3'(c);
      send(8'hA5, 1, c < 4 ? "R1 R3 R5 fmt A5" : "R2 R3 R5 fmt A5");
      wait_idle();
      send(8'h3C, 1, c < 4 ? "R1 R5 fmt 3C" : "R2 R5 fmt 3C");
      wait_idle();
    end
    // R4: bit 7 ignored in 7-bit formats
    fmt = 3'b010;
    send(8'h81, 1, "R4 bit7 ignored even");
    wait_idle();
    fmt = 3'b001;
    send(8'hFF, 1, "R4 bit7 ignored odd");
    wait_idle();

    // R9: back-to-back frames, no gap
    fmt = 3'b101;
    fork
      begin
        send(8'h11, 1, "R9 b2b first");
        send(8'h22, 1, "R9 b2b second");
        send(8'h33, 1, "R9 b2b third");
      end
      begin
        while (!busy) @(negedge clk);
        cnt = 0;
        while (busy && cnt < 100) begin
          cnt++;
          @(negedge clk);
        end
        check(cnt == 30, "R9 continuous busy", cnt, 30);
      end
    join
    wait_idle();

    // R6/R7/R8: divide 16, start latency and ready timing
    div_sel = 2'b01; tick_period = 1; per = 16; fmt = 3'b110;
    send(8'h5A, 1, "R6 div16 frame");
    check(in_ready == 1'b0, "R7 ready low after accept", in_ready, 0);
    cnt = 0;
    while (txd && cnt < 40) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt <= 16, "R8 start within one bit time", cnt, 16);
    check(in_ready == 1'b1, "R7 ready at start bit", in_ready, 1);
    check(busy == 1'b1, "R12 busy in frame", busy, 1);
    wait_idle();

    // R6: divide 64 and code 11
    div_sel = 2'b10; per = 64; fmt = 3'b011;
    send(8'hC3, 1, "R6 div64 frame");
    wait_idle();
    div_sel = 2'b11; tick_period = 2; per = 128; fmt = 3'b111;
    send(8'h96, 1, "R6 div code 11 sparse ticks");
    wait_idle();
    div_sel = 2'b01; tick_period = 3; per = 48; fmt = 3'b000;
    send(8'h4E, 1, "R6 div16 ticks every 3");
    wait_idle();

    // R10: break
    div_sel = 2'b00; tick_period = 1; per = 1; fmt = 3'b101;
    repeat (4) @(negedge clk);
    brk = 1'b1;
    @(negedge clk);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (txd) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R10 line low in break", seen, 0);
    send(8'h77, 0, "");
    repeat (30) @(negedge clk);
    check(in_ready == 1'b0 && busy == 1'b0, "R10 no start in break", {in_ready, busy}, 0);
    check(txd == 1'b0, "R10 line low with byte waiting", txd, 0);
    brk = 1'b0;
    cnt = 0;
    while (!in_ready && cnt < 10) begin
      @(negedge clk);
      cnt++;
    end
    check(in_ready == 1'b1 && busy == 1'b1, "R10 held byte sent after break", {in_ready, busy}, 3);
    wait_idle();

    // R11: master reset mid-frame with a byte waiting
    div_sel = 2'b10; per = 64; fmt = 3'b000;
    send(8'hAA, 0, "");
    send(8'h55, 0, "");
    repeat (200) @(negedge clk);
    check(busy == 1'b1 && in_ready == 1'b0, "R11 pre-reset state", {busy, in_ready}, 2);
    mreset = 1'b1;
    @(negedge clk);
    mreset = 1'b0;
    check(txd == 1'b1 && in_ready == 1'b1 && busy == 1'b0, "R11 after master reset",
          {txd, in_ready, busy}, 6);
    seen = 1'b0;
    for (int i = 0; i < 150; i++) begin
      if (!txd || busy) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R11 waiting byte dropped", seen, 0);

    // Recovery
    div_sel = 2'b00; per = 1; fmt = 3'b111;
    send(8'h0F, 1, "R11 R2 frame after master reset");
    wait_idle();

    check(q.size() == 0, "R3 scoreboard drained", q.size(), 0);
    summary();
  end

endmodule